// File: doc/BRIEF.md
# Direction-Selectable Parametric Shifter

A purely combinational shifter that moves a data word `a` by an amount `b` and presents the outcome on `y`. The widths of `a`, `b` and `y` are independent parameters. Two flags say whether `a` and `b` are two's-complement values. A mode parameter chooses the behaviour:
- fixed-direction logical shifts (left or right)
- fixed-direction arithmetic shifts (left or right)
- a bidirectional shift in which the sign of `b` picks the direction
- an extraction variant of the bidirectional shift that leaves vacated positions undefined, as an indexed part-select does.

The operand is first widened to a working width equal to the larger of the `a` and `y` widths. The shift is done at that width, and the result is then cut to the width of `y`. A second output, `y_known`, marks which result bits carry bits of the widened operand and which are fill. This lets a consumer of the extraction mode, or a two-state simulation, tell data from don't-care.

Top module: `sgn_dir_shifter`

## Requirements
- R1: When A_SGN is non-zero, `a` is sign-extended to the working width; otherwise it is zero-extended. A zero shift returns the widened `a`, cut to Y_W bits.
- R2: In mode SH_LSL, `y` is the widened `a` moved left by the unsigned value of `b`. The low positions fill with 0.
- R3: Mode SH_ASL gives exactly the same result as SH_LSL for every input.
- R4: In mode SH_LSR, `y` is the widened `a` moved right by the unsigned `b`. The high positions fill with 0.
- R5: In mode SH_ASR, the vacated high positions take the top bit of the widened `a`. That bit is `a`'s sign when A_SGN is set, and 0 when it is clear.
- R6: In mode SH_BIDIR, a `b` that is unsigned (B_SGN=0) or non-negative shifts right logically by `b`. A negative `b` shifts left logically by its magnitude. This includes the most negative value, whose magnitude is 2^(B_W-1).
- R7: Mode SH_BIDIR_X moves the data exactly as SH_BIDIR does. Every vacated position of `y` is driven to X, and every position whose `y_known` bit is 1 holds data.
- R8: Bit i of `y_known` is 1 exactly when bit i of `y` carries a bit of the widened operand, and 0 when it is fill. This holds in all modes.
- R9: The working width is max(A_W, Y_W). When Y_W is smaller, the result's low Y_W bits are kept. When Y_W is larger, no operand bit is lost before the cut.
- R10: A shift magnitude of at least the working width gives all-fill: 0 for left and logical shifts, the sign bit for SH_ASR, and X for SH_BIDIR_X. In every mode `y_known` is then all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | A_W | Data operand |
| b | input | B_W | Shift amount; two's complement when B_SGN is set (bidirectional modes only) |
| y | output | Y_W | Shifted result |
| y_known | output | Y_W | 1 where `y` carries operand data, 0 where it is fill |

## Verification
Direction choice and out-of-range clamping can apply to the same vector. The most negative `b` in a bidirectional mode selects a left shift, and its magnitude can also reach the working width, so both take effect together. An arithmetic right shift of a negative operand by an oversize amount likewise combines sign fill with clamping. These cases are driven as directed vectors. Random amounts then cover the whole range of `b`, signed and unsigned. Every instance is judged against a bench model that widens `a` at 64 bits and uses the language's own shift operators. In the extraction mode only the positions flagged by the model's own mask are compared.

// File: rtl/sds_pkg.sv
package sds_pkg;

  typedef enum logic [2:0] {
    SH_LSL     = 3'd0,
    SH_ASL     = 3'd1,
    SH_LSR     = 3'd2,
    SH_ASR     = 3'd3,
    SH_BIDIR   = 3'd4,
    SH_BIDIR_X = 3'd5
  } shmode_e;

  function automatic bit mode_bidir(shmode_e m);
    return (m == SH_BIDIR) || (m == SH_BIDIR_X);
  endfunction

  function automatic bit mode_left_only(shmode_e m);
    return (m == SH_LSL) || (m == SH_ASL);
  endfunction

  function automatic int max_int(int x, int y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/sds_extend.sv
module sds_extend #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 16,
  parameter int SGN   = 0
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      logic pad_bit;
      assign pad_bit = (SGN != 0) ? din[IN_W-1] : 1'b0;
      assign dout    = {{PAD_W{pad_bit}}, din};
    end else begin : g_same
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/sds_amount.sv
module sds_amount
  import sds_pkg::*;
#(
  parameter int      B_W   = 5,
  parameter int      B_SGN = 0,
  parameter int      W     = 16,
  parameter shmode_e MODE  = SH_LSR
) (
  input  logic [B_W-1:0] b,
  output logic           go_left,
  output logic [B_W:0]   shift_mag,
  output logic           oversize
);
  localparam bit CAN_NEG   = mode_bidir(MODE) && (B_SGN != 0);
  localparam bit LEFT_ONLY = mode_left_only(MODE);

  // magnitude of a possibly negative amount, one bit wider so that
  // the most negative value is representable
  function automatic logic [B_W:0] magnitude(logic [B_W-1:0] v, logic neg);
    logic [B_W:0] wide;
    wide = {neg & v[B_W-1], v};
    return neg ? (~wide + 1'b1) : wide;
  endfunction

  logic is_neg;
  assign is_neg    = CAN_NEG & b[B_W-1];
  assign shift_mag = magnitude(b, is_neg);
  assign go_left   = LEFT_ONLY | is_neg;
  assign oversize  = 32'(shift_mag) >= W;
endmodule

// File: rtl/sds_core.sv
module sds_core #(
  parameter int W      = 16,
  parameter int SH_W   = 6,
  parameter bit X_FILL = 1'b0
) (
  input  logic [W-1:0]    word,
  input  logic            go_left,
  input  logic [SH_W-1:0] shift_mag,
  input  logic            oversize,
  input  logic            fill_bit,
  output logic [W-1:0]    res,
  output logic [W-1:0]    data_mask
);
  function automatic logic [W-1:0] move(logic [W-1:0] v, logic left, logic [SH_W-1:0] n);
    return left ? (v << n) : (v >> n);
  endfunction

  logic [W-1:0] raw;

  always_comb begin
    raw       = move(word, go_left, shift_mag);
    data_mask = oversize ? '0 : move({W{1'b1}}, go_left, shift_mag);
    for (int i = 0; i < W; i++) begin
      if (data_mask[i])   res[i] = raw[i];
      else if (X_FILL)    res[i] = 1'bx;
      else if (go_left)   res[i] = 1'b0;
      else                res[i] = fill_bit;
    end
  end
endmodule

// File: rtl/sgn_dir_shifter.sv
module sgn_dir_shifter
  import sds_pkg::*;
#(
  parameter int      A_W   = 16,
  parameter int      B_W   = 5,
  parameter int      Y_W   = 16,
  parameter int      A_SGN = 0,
  parameter int      B_SGN = 0,
  parameter shmode_e MODE  = SH_LSR
) (
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic [Y_W-1:0] y,
  output logic [Y_W-1:0] y_known
);
  localparam int W      = max_int(A_W, Y_W);
  localparam int SH_W   = B_W + 1;
  localparam bit X_FILL = (MODE == SH_BIDIR_X);
  localparam bit SIGN_FILL = (MODE == SH_ASR) && (A_SGN != 0);

  generate
    if (!mode_bidir(MODE) && (B_SGN != 0)) begin : g_bad_sign
      $error("signed shift amount needs a bidirectional mode");
    end
    if (B_W > 30) begin : g_bad_bw
      $error("shift amount width too large");
    end
  endgenerate

  // named internal events, observed by the bound checker
  logic [W-1:0]    ext_word;
  logic            go_left;
  logic [SH_W-1:0] shift_mag;
  logic            oversize;
  logic            fill_bit;
  logic [W-1:0]    res_w;
  logic [W-1:0]    mask_w;
  logic [Y_W-1:0]  ext_low;

  sds_extend #(.IN_W(A_W), .OUT_W(W), .SGN(A_SGN)) u_extend (
    .din  (a),
    .dout (ext_word)
  );

  sds_amount #(.B_W(B_W), .B_SGN(B_SGN), .W(W), .MODE(MODE)) u_amount (
    .b         (b),
    .go_left   (go_left),
    .shift_mag (shift_mag),
    .oversize  (oversize)
  );

  assign fill_bit = SIGN_FILL ? ext_word[W-1] : 1'b0;

  sds_core #(.W(W), .SH_W(SH_W), .X_FILL(X_FILL)) u_core (
    .word      (ext_word),
    .go_left   (go_left),
    .shift_mag (shift_mag),
    .oversize  (oversize),
    .fill_bit  (fill_bit),
    .res       (res_w),
    .data_mask (mask_w)
  );

  assign y       = res_w[Y_W-1:0];
  assign y_known = mask_w[Y_W-1:0];
  assign ext_low = ext_word[Y_W-1:0];

  generate
    if (W > Y_W) begin : g_trim
      logic [2*(W-Y_W)-1:0] trim_unused;
      assign trim_unused = {res_w[W-1:Y_W], mask_w[W-1:Y_W]};
    end
  endgenerate
endmodule

// File: rtl/sds_checker.sv
module sds_checker
  import sds_pkg::*;
#(
  parameter int      Y_W   = 16,
  parameter int      SH_W  = 6,
  parameter int      B_SGN = 0,
  parameter shmode_e MODE  = SH_LSR
) (
  input logic            b_msb,
  input logic [Y_W-1:0]  y,
  input logic [Y_W-1:0]  y_known,
  input logic [Y_W-1:0]  ext_low,
  input logic            go_left,
  input logic [SH_W-1:0] shift_mag,
  input logic            oversize,
  input logic            fill_bit
);
  logic exp_left;
  assign exp_left = mode_left_only(MODE) || (mode_bidir(MODE) && (B_SGN != 0) && b_msb);

  always_comb begin
    p_direction_r6: assert (go_left == exp_left);
    if (oversize) begin
      p_oversize_empty_r10: assert (y_known == '0);
    end
    if (MODE != SH_BIDIR_X) begin
      p_fill_value_r5: assert (((y ^ {Y_W{go_left ? 1'b0 : fill_bit}}) & ~y_known) == '0);
    end
    if (shift_mag == '0) begin
      p_zero_pass_r1: assert ((y == ext_low) && (y_known == {Y_W{1'b1}}));
    end
    if (!oversize && (shift_mag != '0)) begin
      p_known_edge_r8: assert (y_known[0] == !go_left);
    end
  end
endmodule

bind sgn_dir_shifter sds_checker #(
  .Y_W(Y_W), .SH_W(SH_W), .B_SGN(B_SGN), .MODE(MODE)
) i_chk (
  .b_msb     (b[B_W-1]),
  .y         (y),
  .y_known   (y_known),
  .ext_low   (ext_low),
  .go_left   (go_left),
  .shift_mag (shift_mag),
  .oversize  (oversize),
  .fill_bit  (fill_bit)
);

// File: tb/test_sgn_dir_shifter.sv
module test_sgn_dir_shifter;
  import sds_pkg::*;

  localparam int AW = 12;
  localparam int BW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] a_in = '0;
  logic [BW-1:0] b_in = '0;

  logic [15:0] y_ll, k_ll, y_al, k_al, y_lr, k_lr, y_ar, k_ar, y_az, k_az, y_bu, k_bu;
  logic [7:0]  y_bd, k_bd, y_bx, k_bx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sgn_dir_shifter #(.A_W(AW), .B_W(BW), .Y_W(8), .A_SGN(0), .B_SGN(1), .MODE(SH_BIDIR))
    i_sgn_dir_shifter (.a(a_in), .b(b_in), .y(y_bd), .y_known(k_bd));
  sgn_dir_shifter #(.A_W(AW), .B_W(BW), .Y_W(16), .A_SGN(1), .B_SGN(0), .MODE(SH_LSL))
    u_ll (.a(a_in), .b(b_in), .y(y_ll), .y_known(k_ll));
  sgn_dir_shifter #(.A_W(AW), .B_W(BW), .Y_W(16), .A_SGN(1), .B_SGN(0), .MODE(SH_ASL))
    u_al (.a(a_in), .b(b_in), .y(y_al), .y_known(k_al));
  sgn_dir_shifter #(.A_W(AW), .B_W(BW), .Y_W(16), .A_SGN(1), .B_SGN(0), .MODE(SH_LSR))
    u_lr (.a(a_in), .b(b_in), .y(y_lr), .y_known(k_lr));
  sgn_dir_shifter #(.A_W(AW), .B_W(BW), .Y_W(16), .A_SGN(1), .B_SGN(0), .MODE(SH_ASR))
    u_ar (.a(a_in), .b(b_in), .y(y_ar), .y_known(k_ar));
  sgn_dir_shifter #(.A_W(AW), .B_W(BW), .Y_W(16), .A_SGN(0), .B_SGN(0), .MODE(SH_ASR))
    u_az (.a(a_in), .b(b_in), .y(y_az), .y_known(k_az));
  sgn_dir_shifter #(.A_W(AW), .B_W(BW), .Y_W(8), .A_SGN(0), .B_SGN(1), .MODE(SH_BIDIR_X))
    u_bx (.a(a_in), .b(b_in), .y(y_bx), .y_known(k_bx));
  sgn_dir_shifter #(.A_W(AW), .B_W(BW), .Y_W(16), .A_SGN(1), .B_SGN(0), .MODE(SH_BIDIR))
    u_bu (.a(a_in), .b(b_in), .y(y_bu), .y_known(k_bu));

  // bench model: widen at 64 bits, use the language's shift operators
  function automatic logic [63:0] model(shmode_e m, int asg, int bsg, int yw,
                                        logic [AW-1:0] av, logic [BW-1:0] bv, bit want_mask);
    int w;
    int n;
    bit left;
    logic [63:0] ext, ones, src, r;
    w    = (AW > yw) ? AW : yw;
    ext  = {52'd0, av};
    if (asg != 0 && av[AW-1]) ext = ext | ~((64'd1 << AW) - 1);
    ones = (64'd1 << w) - 1;
    if ((m == SH_BIDIR || m == SH_BIDIR_X) && bsg != 0 && bv[BW-1]) begin
      n = (1 << BW) - int'(bv);
      left = 1;
    end else begin
      n = int'(bv);
      left = (m == SH_LSL || m == SH_ASL);
    end
    src = want_mask ? ones : ext;
    if (left)                          r = src << n;
    else if (m == SH_ASR && !want_mask) r = $unsigned($signed(ext) >>> n);
    else                               r = (src & ones) >> n;
    return r & ((64'd1 << yw) - 1);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a_in, b_in, act, exp);
    end
  endtask

  task automatic apply(logic [AW-1:0] av, logic [BW-1:0] bv);
    @(posedge clk);
    a_in = av;
    b_in = bv;
    @(negedge clk);
  endtask

  task automatic check_all();
    logic [63:0] m;
    check("R2", {48'd0, y_ll}, model(SH_LSL, 1, 0, 16, a_in, b_in, 0));
    check("R3", {48'd0, y_al}, {48'd0, y_ll});
    check("R3", {48'd0, y_al}, model(SH_ASL, 1, 0, 16, a_in, b_in, 0));
    check("R4", {48'd0, y_lr}, model(SH_LSR, 1, 0, 16, a_in, b_in, 0));
    check("R5", {48'd0, y_ar}, model(SH_ASR, 1, 0, 16, a_in, b_in, 0));
    check("R5", {48'd0, y_az}, model(SH_ASR, 0, 0, 16, a_in, b_in, 0));
    check("R6", {56'd0, y_bd}, model(SH_BIDIR, 0, 1, 8, a_in, b_in, 0));
    check("R6", {48'd0, y_bu}, model(SH_BIDIR, 1, 0, 16, a_in, b_in, 0));
    m = model(SH_BIDIR_X, 0, 1, 8, a_in, b_in, 1);
    check("R7", {56'd0, y_bx & k_bx}, model(SH_BIDIR_X, 0, 1, 8, a_in, b_in, 0) & m);
    check("R7", {56'd0, k_bx}, m);
    check("R8", {48'd0, k_ll}, model(SH_LSL, 1, 0, 16, a_in, b_in, 1));
    check("R8", {48'd0, k_ar}, model(SH_ASR, 1, 0, 16, a_in, b_in, 1));
    check("R8", {56'd0, k_bd}, model(SH_BIDIR, 0, 1, 8, a_in, b_in, 1));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h1A2B);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // quiet state: zero operand gives zero result and full data mask
    check("R1", {48'd0, y_ll}, 64'h0);
    check("R8", {48'd0, k_ll}, 64'hFFFF);

    // R1: sign extension of a negative operand at zero shift
    apply(12'h800, 5'd0);
    check("R1", {48'd0, y_ll}, 64'hF800);
    check("R1", {48'd0, y_bu}, 64'hF800);
    check_all();
    // R9: narrower result keeps the low bits
    apply(12'hABC, 5'd0);
    check("R9", {56'd0, y_bd}, 64'hBC);
    check_all();
    // R9: right shift brings upper operand bits into a narrow result
    apply(12'hABC, 5'd4);
    check("R9", {56'd0, y_bd}, 64'hAB);
    check_all();
    // R6: negative amount shifts left
    apply(12'h0F3, 5'h1F);
    check("R6", {56'd0, y_bd}, 64'hE6);
    check_all();
    // R6 and R10: most negative amount is a left shift beyond the width
    apply(12'hFFF, 5'h10);
    check("R10", {56'd0, k_bd}, 64'h0);
    check("R10", {56'd0, y_bd}, 64'h0);
    check_all();
    // R10: sign fill with oversize amount
    apply(12'h9A5, 5'd16);
    check("R10", {48'd0, y_ar}, 64'hFFFF);
    check("R10", {48'd0, k_ar}, 64'h0);
    check_all();
    apply(12'h9A5, 5'd31);
    check("R10", {48'd0, y_lr}, 64'h0);
    check_all();
    // R5: boundary just inside the working width
    apply(12'h800, 5'd15);
    check("R5", {48'd0, y_ar}, 64'hFFFF);
    check("R5", {48'd0, y_az}, 64'h0);
    check_all();
    // R7: largest positive amount in the extraction mode
    apply(12'hFFF, 5'h0F);
    check_all();
    for (int i = 0; i < 400; i++) begin
      apply(12'($urandom), 5'($urandom));
      check_all();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule